// File: doc/BRIEF.md
# Bidirectional Mesh-of-Trees Neural Layer Engine

This block evaluates one fully connected neural layer on an N×N grid of multiply cells, where N is a power of two. Every column has a binary broadcast tree, and a column appendix sits at its root. Every row has a binary adder tree, and a row appendix sits at its root. An appendix does one of two jobs in a layer. It is either a source that injects an activation into its tree, or a destination that turns the weighted sum arriving from its tree into an activation.

Odd layers run from the column appendices to the row appendices. Even layers run the other way, from the rows back to the columns. For an even layer the weight grid is written transposed. The results of one layer therefore become the sources of the next one in place, and nothing has to be copied between layers. Only layer index 1 loads fresh inputs into the column appendices.

Activations and weights are signed Q4.12 values. The activation function is a 32-segment piecewise-linear sigmoid. Every tree level is one register stage, so the latency of a layer is fixed.

Top module: `mot_layer`

## Requirements
- R1: After reset, every column appendix, every row appendix and every grid weight is zero, and `done` is low.
- R2: For an odd `layer`, row appendix i receives f(h_i), where h_i = Σ_j cell(i,j)·col(j). The column appendices are the sources.
- R3: For an even `layer`, column appendix m receives f(h_m), where h_m = Σ_k cell(k,m)·row(k). The row appendices are the sources. For this reason an even layer's natural matrix V is written with V[m][k] placed into cell (k,m).
- R4: The weighted sum h is a full-precision Q8.24 value. It is reduced to x = floor(h / 4096) and then clamped to the range [-32768, 32767], which is the interval [-8, +8) in Q4.12.
- R5: f(x) is computed as follows.
  - idx = (x+32768) >> 11 and fr = (x+32768) mod 2048.
  - knot(k) = round(4096 / (1 + e^-(k/2 - 8))) for k = 0..32.
  - f = knot(idx) + floor((knot(idx+1) − knot(idx))·fr / 2048).
  - For example, x = 0 gives 2048 and x = 4096 gives 2994.
- R6: The destination appendices change, and `done` is high, in the cycle that follows the 2·log2(N)+4-th rising edge after the edge that accepted `start`. This is 8 edges for N = 4.
- R7: `done` is high for exactly one cycle per accepted layer.
- R8: A `start` seen while a layer is in flight is ignored. It does not change the latency, the sources or the results.
- R9: `layer` = 1 loads `act_in` into the column appendices. Any other index keeps the existing source values. The source appendices of a layer are not modified by that layer.
- R10: When `w_we` is high on a rising edge, `w_data` is written into grid cell (`w_row`, `w_col`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to evaluate a layer |
| layer | input | LW | Layer index; bit 0 selects the direction, and value 1 loads inputs |
| act_in | input | N·W | Q4.12 inputs for the column appendices; slot j is bits [j·W +: W] |
| w_we | input | 1 | Weight write enable |
| w_row | input | log2(N) | Row of the weight cell being written |
| w_col | input | log2(N) | Column of the weight cell being written |
| w_data | input | W | Q4.12 weight value |
| col_out | output | N·W | Column appendix contents, slot j at [j·W +: W] |
| row_out | output | N·W | Row appendix contents, slot i at [i·W +: W] |
| done | output | 1 | One-cycle pulse when the destination appendices hold the layer result |

## Verification
The assertions take three things for granted about the inputs:
- The weight grid is not rewritten while a layer is in flight, because the grid is read several stages after `start` is accepted.
- `start` is a single-cycle pulse.
- N is a power of two of at least 2.

The stimulus keeps within these limits. It writes weights only while the engine is idle, and it raises `start` for one cycle at a time. The only exception is the deliberate second pulse that is sent mid-layer to exercise R8.

// File: rtl/mot_layer.sv
module mot_layer #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int FR = 12,
  parameter int LW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LW-1:0]          layer,
  input  logic [N*W-1:0]         act_in,
  input  logic                   w_we,
  input  logic [$clog2(N)-1:0]   w_row,
  input  logic [$clog2(N)-1:0]   w_col,
  input  logic [W-1:0]           w_data,
  output logic [N*W-1:0]         col_out,
  output logic [N*W-1:0]         row_out,
  output logic                   done
);
  localparam int LG  = $clog2(N);
  localparam int PW  = 2*W;
  localparam int AW  = PW + LG;
  localparam int TOT = 2*LG + 4;
  localparam int CW  = $clog2(TOT+1);
  localparam int SB  = FR - 1;
  localparam int ONE = 1 << FR;
  localparam logic signed [AW-1:0] XMAX = AW'((1 << (W-1)) - 1);
  localparam logic signed [AW-1:0] XMIN = ~XMAX;

  logic          busy, odd;
  logic [CW-1:0] cnt;
  logic signed [W-1:0]  wt   [N][N];
  logic signed [W-1:0]  capp [N];
  logic signed [W-1:0]  rapp [N];
  logic signed [W-1:0]  bc   [LG+1][N];
  logic signed [PW-1:0] prod [N][N];
  logic signed [AW-1:0] lv   [N][N];
  logic signed [AW-1:0] tr   [N][N];
  logic signed [AW-1:0] hreg [N];

  wire fin = busy && (cnt == CW'(TOT-1));

  function automatic int knotv(input int k);
    int a, p;
    a = (k >= 16) ? k - 16 : 16 - k;
    case (a)
      0: p = 2048;  1: p = 2550;  2: p = 2994;  3: p = 3349;
      4: p = 3608;  5: p = 3785;  6: p = 3902;  7: p = 3976;
      8: p = 4022;  9: p = 4051; 10: p = 4069; 11: p = 4079;
     12: p = 4086; 13: p = 4090; 14: p = 4092; 15: p = 4094;
      default: p = 4095;
    endcase
    return (k >= 16) ? p : ONE - p;
  endfunction

  function automatic logic [W-1:0] sig(input logic signed [AW-1:0] h);
    logic signed [AW-1:0] s;
    logic [W-1:0] x;
    int idx, fr, lo, hi;
    s   = h >>> FR;
    x   = (s > XMAX) ? XMAX[W-1:0] : (s < XMIN) ? XMIN[W-1:0] : s[W-1:0];
    idx = int'({~x[W-1], x[W-2:SB]});
    fr  = int'(x[SB-1:0]);
    lo  = knotv(idx);
    hi  = knotv(idx + 1);
    return W'(lo + (((hi - lo) * fr) >>> SB));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; odd <= 1'b1; done <= 1'b0;
    end else begin
      done <= fin;
      if (fin) busy <= 1'b0;
      else if (busy) cnt <= cnt + CW'(1);
      else if (start) begin
        busy <= 1'b1; cnt <= '0; odd <= layer[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin capp[k] <= '0; rapp[k] <= '0; end
    end else begin
      if (!busy && start && layer == LW'(1))
        for (int k = 0; k < N; k++) capp[k] <= act_in[k*W +: W];
      if (fin)
        for (int m = 0; m < N; m++)
          if (odd) rapp[m] <= sig(hreg[m]);
          else     capp[m] <= sig(hreg[m]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) wt[i][j] <= '0;
    end else if (w_we) begin
      wt[w_row][w_col] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      bc[0][k] <= odd ? capp[k] : rapp[k];
      for (int l = 1; l <= LG; l++) bc[l][k] <= bc[l-1][k];
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        prod[i][j] <= wt[i][j] * (odd ? bc[LG][j] : bc[LG][i]);
    for (int m = 0; m < N; m++) begin
      for (int k = 0; k < N; k++) begin
        if (k == 0)          tr[m][k] <= '0;
        else if (2*k >= N)   tr[m][k] <= lv[m][(2*k) % N] + lv[m][(2*k+1) % N];
        else                 tr[m][k] <= tr[m][(2*k) % N] + tr[m][(2*k+1) % N];
      end
      hreg[m] <= tr[m][1];
    end
  end

  always_comb
    for (int m = 0; m < N; m++)
      for (int q = 0; q < N; q++)
        lv[m][q] = odd ? AW'(prod[m][q]) : AW'(prod[q][m]);

  for (genvar k = 0; k < N; k++) begin : g_out
    assign col_out[k*W +: W] = capp[k];
    assign row_out[k*W +: W] = rapp[k];
    assert_out_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((odd ? rapp[k] : capp[k]) >= 0 && (odd ? rapp[k] : capp[k]) < ONE));
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin) |=> (busy && cnt == $past(cnt) + CW'(1)));
  assert_src_stable_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && odd) |-> $stable(col_out));
  assert_src_stable_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !odd) |-> $stable(row_out));
endmodule

// File: tb/sim_mot_layer.sv
module sim_mot_layer;
  localparam int N = 4, W = 16, LW = 4, LG = 2, TOT = 2*LG + 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, w_we = 1'b0;
  logic [LW-1:0] layer = '0;
  logic [N*W-1:0] act_in = '0;
  logic [LG-1:0] w_row = '0, w_col = '0;
  logic [W-1:0] w_data = '0;
  wire  [N*W-1:0] col_out, row_out;
  wire  done;

  mot_layer #(.N(N), .W(W), .FR(12), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .layer(layer), .act_in(act_in),
    .w_we(w_we), .w_row(w_row), .w_col(w_col), .w_data(w_data),
    .col_out(col_out), .row_out(row_out), .done(done));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit over = 1'b0;
  int mcol[N], mrow[N], mres[N], wcell[N][N];
  int mbusy = 0, mcnt = 0, mdone = 0, mdir = 0;

  function automatic int kn(input int k);
    real x;
    x = -8.0 + 0.5 * k;
    return int'($floor(4096.0 / (1.0 + $exp(-x)) + 0.5));
  endfunction

  function automatic int rsig(input longint h);
    longint x;
    int idx, fr, lo, hi;
    x = h >>> 12;
    if (x > 32767) x = 32767;
    if (x < -32768) x = -32768;
    idx = int'((x + 32768) / 2048);
    fr  = int'((x + 32768) % 2048);
    lo = kn(idx); hi = kn(idx + 1);
    return lo + ((hi - lo) * fr) / 2048;
  endfunction

  function automatic int slice(input logic [N*W-1:0] v, input int k);
    return int'($signed(v[k*W +: W]));
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    longint h;
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        mcol[k] = 0; mrow[k] = 0;
        for (int j = 0; j < N; j++) wcell[k][j] = 0;
      end
      mbusy = 0; mcnt = 0; mdone = 0;
    end else begin
      if (w_we) wcell[w_row][w_col] = int'($signed(w_data));
      mdone = 0;
      if (mbusy != 0) begin
        if (mcnt == TOT - 1) begin
          for (int m = 0; m < N; m++)
            if (mdir != 0) mrow[m] = mres[m]; else mcol[m] = mres[m];
          mbusy = 0; mdone = 1;
        end else mcnt++;
      end else if (start) begin
        mbusy = 1; mcnt = 0; mdir = int'(layer[0]);
        if (layer == 1) for (int k = 0; k < N; k++) mcol[k] = slice(act_in, k);
        for (int m = 0; m < N; m++) begin
          h = 0;
          for (int k = 0; k < N; k++)
            if (mdir != 0) h += longint'(wcell[m][k]) * mcol[k];
            else           h += longint'(wcell[k][m]) * mrow[k];
          mres[m] = rsig(h);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !over) begin
      nchk++;
      if (done !== mdone[0]) begin
        nfail++;
        $display("FAIL R7 done got %0d exp %0d", done, mdone);
      end
      for (int k = 0; k < N; k++) begin
        nchk += 2;
        if (slice(col_out, k) != mcol[k]) begin
          nfail++;
          $display("FAIL %s col_out[%0d] got %0d exp %0d", (mdir != 0) ? "R9" : "R3",
                   k, slice(col_out, k), mcol[k]);
        end
        if (slice(row_out, k) != mrow[k]) begin
          nfail++;
          $display("FAIL %s row_out[%0d] got %0d exp %0d", (mdir != 0) ? "R2" : "R9",
                   k, slice(row_out, k), mrow[k]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input int j, input int v);
    @(negedge clk);
    w_we = 1'b1; w_row = LG'(i); w_col = LG'(j); w_data = W'(v);
    @(negedge clk);
    w_we = 1'b0;
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wr(i, j, v);
  endtask

  task automatic run(input int lay, input logic [N*W-1:0] a, input bit imm,
                     input bit poke, output int lat);
    if (!imm) @(negedge clk);
    start = 1'b1; layer = LW'(lay); act_in = a; lat = 0;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done) begin
      @(negedge clk); lat++;
      if (poke && lat == 3) begin start = 1'b1; layer = LW'(1); act_in = ~a; end
      else start = 1'b0;
    end
  endtask

  function automatic logic [N*W-1:0] pack(input int a0, input int a1, input int a2, input int a3);
    return {W'(a3), W'(a2), W'(a1), W'(a0)};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!over) begin
      over = 1'b1; nfail++;
      $display("FAIL R6 watchdog expired got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lat;
    int keep[N];
    logic [N*W-1:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    for (int k = 0; k < N; k++) begin
      chk("R1 col", slice(col_out, k), 0);
      chk("R1 row", slice(row_out, k), 0);
    end

    // R10: one weight in cell (1,2)
    wr(1, 2, 4096);
    run(1, pack(0, 0, 4096, 0), 1'b0, 1'b0, lat);
    chk("R6 latency", lat, TOT + 1);
    chk("R10 row1", slice(row_out, 1), 2994);
    chk("R5 row0 zero sum", slice(row_out, 0), 2048);

    // R2: odd layer, general weights
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wr(i, j, (i + 1) * 1024 - j * 768);
    a = pack(4096, -2048, 1024, 3072);
    run(1, a, 1'b0, 1'b0, lat);
    for (int k = 0; k < N; k++) chk("R9 inputs kept", slice(col_out, k), slice(a, k));
    for (int k = 0; k < N; k++) keep[k] = slice(row_out, k);

    // R3: even layer, transposed natural matrix V[i][j] into cell (j,i)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wr(j, i, 2048 - i * 512 + j * 256 - ((i == j) ? 4096 : 0));
    run(2, pack(111, 222, 333, 444), 1'b0, 1'b0, lat);
    chk("R6 latency even", lat, TOT + 1);
    for (int k = 0; k < N; k++) chk("R9 row source kept", slice(row_out, k), keep[k]);
    for (int k = 0; k < N; k++) chk("R3 col result", slice(col_out, k), mcol[k]);
    for (int k = 0; k < N; k++) keep[k] = slice(col_out, k);

    // odd layer 3 reuses the column results without reloading
    run(3, pack(-1, -1, -1, -1), 1'b0, 1'b0, lat);
    for (int k = 0; k < N; k++) chk("R9 col source kept", slice(col_out, k), keep[k]);
    for (int k = 0; k < N; k++) chk("R2 row result", slice(row_out, k), mrow[k]);

    // R4: saturation on both sides
    fill(32767);
    run(1, pack(32767, 32767, 32767, 32767), 1'b0, 1'b0, lat);
    chk("R4 clamp high", slice(row_out, 2), 4094);
    fill(-32768);
    run(1, pack(32767, 32767, 32767, 32767), 1'b0, 1'b0, lat);
    chk("R4 clamp low", slice(row_out, 3), 1);

    // R8: start pulsed mid-layer is ignored
    fill(1024);
    a = pack(2048, 4096, -4096, 1024);
    run(1, a, 1'b0, 1'b1, lat);
    chk("R8 latency unchanged", lat, TOT + 1);
    for (int k = 0; k < N; k++) chk("R8 inputs not reloaded", slice(col_out, k), slice(a, k));

    // back-to-back: start in the cycle that done is high
    run(2, '0, 1'b1, 1'b0, lat);
    chk("R6 back-to-back latency", lat, TOT + 1);
    @(negedge clk);
    chk("R7 done single cycle", int'(done), 0);

    over = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule